// File: doc/BRIEF.md
# DMA Request Channel Router

This block sits between the peripherals that raise DMA requests and the channels of a DMA controller. Each of sixteen output channels owns a one-byte configuration register. The register picks one of twenty-one peripheral request lines and sets the channel's mode. A channel can be off, pass its chosen line straight through, or hold that line back until an external periodic trigger pulse has armed the channel.

Software programs the channels through a byte-wide port. The port has a write strobe, an address equal to the channel number and a combinational read-back. Only the four lowest channels have trigger inputs that matter. The timer that makes the pulses, the DMA engine and the acknowledge path back to the peripherals all live outside this block. The only acknowledge seen here is the per-channel one that ends a triggered request.

Top module: `dma_req_router`

## Requirements
- R1: After reset every configuration register reads 0x00 and every channel output is low, whatever the request inputs do.
- R2: The register of channel n is at address n. In the byte, bit 7 is the enable, bit 6 is the trigger enable and bits 4:0 are the source select. Bit 5 always reads 0. Read data follows the address in the same cycle.
- R3: With enable=1 and trigger enable=0, the channel output equals request input number `select` in the same cycle, for every select value from 0 to 20.
- R4: With enable=0 the channel output is low. The stored source select is kept, shown in read-back, and used again when the channel is re-enabled.
- R5: A source select from 21 to 31 never produces a request.
- R6: On channels 4 to 15, the trigger-enable bit is discarded on write and reads 0. Such a channel routes as in R3 when enabled, with no trigger pulse.
- R7: On channels 0 to 3 with enable=1 and trigger enable=1, the output is low until a pulse on the channel's trigger input arms the channel at the next clock edge. While the channel is armed, the output follows the selected request.
- R8: A triggered channel leaves the armed state at the clock edge after a cycle in which its acknowledge is high while its output is high. A trigger pulse in that same cycle keeps the channel armed.
- R9: In a cycle where the port writes a channel's address, that channel's output is low. The new setting applies from the next edge, and the write discards any armed state.
- R10: Once armed, a channel stays armed through any number of cycles with its request low, and forwards the next request that is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Channel number for write and read |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration byte of the addressed channel |
| src_req | input | 21 | Peripheral request lines |
| trig_pulse | input | 4 | Periodic trigger pulses for channels 0 to 3 |
| ch_ack | input | 16 | Per-channel acknowledge from the DMA controller |
| ch_req | output | 16 | Routed request per channel |

## Verification
Re-arming and retiring can fall in the same cycle on a triggered channel. A trigger pulse can arrive in the cycle where the controller acknowledges the forwarded request. The bench arms channel 2, holds its request high, and then raises acknowledge and trigger together for one cycle. It expects the output still high afterwards, and it checks separately that acknowledge alone drops it. A configuration write can also land in the same cycle as a live forwarded request. The output is judged low in that very cycle and routed to the new source one edge later.

// File: rtl/dma_rtr_pkg.sv
package dma_rtr_pkg;

  localparam int SEL_W = 5;

  typedef struct packed {
    logic             en;
    logic             trg;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;

  // Byte -> fields; trigger bit dropped where the channel cannot use it
  function automatic chan_cfg_t cfg_unpack(input logic [7:0] b, input logic trig_ok);
    chan_cfg_t c;
    c.en  = b[7];
    c.trg = b[6] & trig_ok;
    c.sel = b[SEL_W-1:0];
    return c;
  endfunction

  // Fields -> byte, bit 5 always zero
  function automatic logic [7:0] cfg_pack(input chan_cfg_t c);
    return {c.en, c.trg, 1'b0, c.sel};
  endfunction

  // Pick request line; select values beyond the source count give nothing
  function automatic logic src_pick(input logic [31:0] src, input logic [SEL_W-1:0] sel,
                                    input int num_src);
    if (int'(sel) >= num_src) return 1'b0;
    return src[sel];
  endfunction

endpackage

// File: rtl/dma_rtr_regs.sv
module dma_rtr_regs
  import dma_rtr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4,
  parameter int ADDR_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output chan_cfg_t [NUM_CH-1:0] cfg,
  output logic [NUM_CH-1:0]     wr_hit
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    localparam logic TRIG_OK = (i < NUM_TRIG_CH);
    assign wr_hit[i] = we && (int'(addr) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg[i] <= '0;
      else if (wr_hit[i]) cfg[i] <= cfg_unpack(wdata, TRIG_OK);
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (int'(addr) < NUM_CH) rdata = cfg_pack(cfg[addr]);
  end

endmodule

// File: rtl/dma_rtr_chan.sv
module dma_rtr_chan
  import dma_rtr_pkg::*;
#(
  parameter int   NUM_SRC = 21,
  parameter logic TRIG_OK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chan_cfg_t          cfg,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               trig,
  input  logic               ack,
  input  logic               wr_hit,
  output logic               req,
  output logic               armed
);

  logic picked;
  logic periodic;

  assign picked   = src_pick(32'(src_req), cfg.sel, NUM_SRC);
  assign periodic = cfg.en & cfg.trg;

  if (TRIG_OK) begin : g_trig
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed_q <= 1'b0;
      else if (!periodic || wr_hit) armed_q <= 1'b0;
      else if (trig)               armed_q <= 1'b1;
      else if (ack && req)         armed_q <= 1'b0;
    end
    assign armed = armed_q;
  end else begin : g_plain
    assign armed = 1'b0;
  end

  always_comb begin
    req = 1'b0;
    if (cfg.en && !wr_hit) req = picked & (cfg.trg ? armed : 1'b1);
  end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_rtr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_SRC     = 21,
  parameter int NUM_TRIG_CH = 4,
  localparam int ADDR_W     = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_rdata,
  input  logic [NUM_SRC-1:0]     src_req,
  input  logic [NUM_TRIG_CH-1:0] trig_pulse,
  input  logic [NUM_CH-1:0]      ch_ack,
  output logic [NUM_CH-1:0]      ch_req
);

  chan_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0] wr_hit;
  logic [NUM_CH-1:0] chan_armed;
  logic [NUM_CH-1:0] cfg_en;
  logic [NUM_CH-1:0] cfg_trg;

  dma_rtr_regs #(
    .NUM_CH(NUM_CH), .NUM_TRIG_CH(NUM_TRIG_CH), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .wr_hit(wr_hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic trig_i;
    if (i < NUM_TRIG_CH) begin : g_t
      assign trig_i = trig_pulse[i];
    end else begin : g_n
      assign trig_i = 1'b0;
    end
    assign cfg_en[i]  = cfg[i].en;
    assign cfg_trg[i] = cfg[i].trg;
    dma_rtr_chan #(
      .NUM_SRC(NUM_SRC), .TRIG_OK(i < NUM_TRIG_CH)
    ) i_chan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[i]), .src_req(src_req), .trig(trig_i),
      .ack(ch_ack[i]), .wr_hit(wr_hit[i]), .req(ch_req[i]), .armed(chan_armed[i])
    );
  end

endmodule

// File: rtl/dma_rtr_chk.sv
module dma_rtr_chk #(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0]      cfg_en,
  input logic [NUM_CH-1:0]      cfg_trg,
  input logic [NUM_CH-1:0]      chan_armed,
  input logic [NUM_CH-1:0]      wr_hit,
  input logic [NUM_TRIG_CH-1:0] trig_pulse,
  input logic [NUM_CH-1:0]      ch_ack,
  input logic [NUM_CH-1:0]      ch_req
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R4
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en[i] |-> !ch_req[i]);
    // R9
    a_r9_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |-> !ch_req[i]);
    // R7
    a_r7_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_trg[i] && !chan_armed[i]) |-> !ch_req[i]);
    if (i < NUM_TRIG_CH) begin : g_t
      // R7
      a_r7_pulse_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse[i] && cfg_en[i] && cfg_trg[i] && !wr_hit[i]) |=> chan_armed[i]);
      // R8
      a_r8_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_armed[i] && ch_req[i] && ch_ack[i] && !trig_pulse[i]) |=> !chan_armed[i]);
    end else begin : g_n
      // R6
      a_r6_no_trig_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_trg[i]);
    end
  end

endmodule

bind dma_req_router dma_rtr_chk #(.NUM_CH(NUM_CH), .NUM_TRIG_CH(NUM_TRIG_CH)) i_chk (.*);

// File: tb/test_dma_req_router.sv
module test_dma_req_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [20:0] src_req = '0;
  logic [3:0]  trig_pulse = '0;
  logic [15:0] ch_ack = '0;
  logic [15:0] ch_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_req_router i_dma_req_router (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = 4'(ch); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    #2;
  endtask

  task automatic rd(input int ch, input logic [7:0] exp, input string tag);
    cfg_addr = 4'(ch); #1;
    chk(32'(cfg_rdata), 32'(exp), tag);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); trig_pulse[ch] = 1'b1;
    @(negedge clk); trig_pulse[ch] = 1'b0;
    #2;
  endtask

  // {channel, config byte, source index to raise, expected output}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {4'd0,  8'h80, 5'd0,  1'b1},
    {4'd3,  8'h94, 5'd20, 1'b1},
    {4'd5,  8'h8A, 5'd10, 1'b1},
    {4'd5,  8'h8A, 5'd11, 1'b0},
    {4'd9,  8'h0A, 5'd10, 1'b0},
    {4'd12, 8'h95, 5'd21, 1'b0},
    {4'd15, 8'h9F, 5'd31, 1'b0},
    {4'd8,  8'hC6, 5'd6,  1'b1},
    {4'd14, 8'h8F, 5'd15, 1'b1},
    {4'd1,  8'h81, 5'd1,  1'b1}
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    src_req = '1;
    #2;
    // R1: reset state
    chk(32'(ch_req), 0, "R1 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk); #2;
    for (int c = 0; c < 16; c++) rd(c, 8'h00, "R1 reg after reset");
    chk(32'(ch_req), 0, "R1 outputs after reset");
    src_req = '0;

    // R3 R5 R6: table walk
    for (int v = 0; v < NV; v++) begin
      logic [3:0] ch; logic [7:0] cb; logic [4:0] si; logic ex;
      {ch, cb, si, ex} = VEC[v];
      wr(int'(ch), cb);
      src_req = '0;
      if (si < 21) src_req[si] = 1'b1;
      if (si >= 21) src_req = '1;
      #2;
      chk(32'(ch_req[ch]), 32'(ex), "R3 R5 R6 table routing");
      wr(int'(ch), 8'h00);
    end
    src_req = '0;

    // R3: every source on channel 5, single line high
    for (int s = 0; s < 21; s++) begin
      wr(5, 8'h80 | 8'(s));
      src_req = 21'(1) << s; #2;
      chk(32'(ch_req), 32'(16'(1) << 5), "R3 each source");
      src_req = '1 ^ (21'(1) << s); #2;
      chk(32'(ch_req[5]), 0, "R3 other sources ignored");
      src_req = '0;
    end
    wr(5, 8'h00);

    // R2: layout and bit 5
    wr(0, 8'hFF);  rd(0, 8'hDF, "R2 trig channel readback");
    wr(10, 8'hFF); rd(10, 8'h9F, "R2 R6 plain channel readback");
    wr(0, 8'h00);  wr(10, 8'h00);
    wr(13, 8'h47); rd(13, 8'h07, "R6 trig bit dropped");
    rd(12, 8'h00, "R2 neighbour untouched");

    // R4: disable keeps selection
    wr(6, 8'h89); src_req[9] = 1'b1; #2;
    chk(32'(ch_req[6]), 1, "R4 enabled routes");
    wr(6, 8'h09); rd(6, 8'h09, "R4 select kept");
    chk(32'(ch_req[6]), 0, "R4 disabled quiet");
    cfg_wdata = 8'h89; cfg_addr = 4'd6;
    wr(6, 8'h89);
    chk(32'(ch_req[6]), 1, "R4 re-enabled");
    wr(6, 8'h00); src_req = '0;

    // R7 R10: periodic on channel 2, select 3
    wr(2, 8'hC3); src_req[3] = 1'b1; #2;
    chk(32'(ch_req[2]), 0, "R7 unarmed quiet");
    src_req[3] = 1'b0;
    pulse(2);
    repeat (3) @(negedge clk); #2;
    chk(32'(ch_req[2]), 0, "R10 armed waits");
    src_req[3] = 1'b1; #2;
    chk(32'(ch_req[2]), 1, "R10 armed forwards");
    chk(32'(ch_req[0]), 0, "R7 other channel quiet");

    // R8: ack together with trigger keeps armed
    @(negedge clk); ch_ack[2] = 1'b1; trig_pulse[2] = 1'b1;
    @(negedge clk); ch_ack[2] = 1'b0; trig_pulse[2] = 1'b0; #2;
    chk(32'(ch_req[2]), 1, "R8 trigger beats ack");
    // R8: ack alone retires
    @(negedge clk); ch_ack[2] = 1'b1;
    @(negedge clk); ch_ack[2] = 1'b0; #2;
    chk(32'(ch_req[2]), 0, "R8 ack retires");

    // R9: write blanks and discards armed
    pulse(2);
    chk(32'(ch_req[2]), 1, "R9 setup armed");
    @(negedge clk); cfg_addr = 4'd2; cfg_wdata = 8'hC3; cfg_we = 1'b1; #2;
    chk(32'(ch_req[2]), 0, "R9 blank in write cycle");
    @(negedge clk); cfg_we = 1'b0; #2;
    chk(32'(ch_req[2]), 0, "R9 armed discarded");

    // R9: normal-mode retarget takes effect next edge
    wr(7, 8'h84); src_req = '0; src_req[4] = 1'b1; src_req[8] = 1'b1; #2;
    chk(32'(ch_req[7]), 1, "R9 before retarget");
    src_req[4] = 1'b0;
    @(negedge clk); cfg_addr = 4'd7; cfg_wdata = 8'h88; cfg_we = 1'b1; #2;
    chk(32'(ch_req[7]), 0, "R9 retarget blank");
    @(negedge clk); cfg_we = 1'b0; #2;
    chk(32'(ch_req[7]), 1, "R9 new source routed");

    // R6: trigger enable on plain channel routes without pulse
    wr(11, 8'hC8); #2;
    chk(32'(ch_req[11]), 1, "R6 plain channel ignores trig bit");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule